// File: doc/BRIEF.md
# Programmable Up/Down Waveform Timer

This block is a 16-bit counter with two compare channels that each drive a waveform pin. The counter steps once per cycle in which the `tick` input is high and the run bit is set. A kind field selects how it counts: free-running, clear at the ceiling, single-slope PWM, or dual-slope (up then down) PWM. The ceiling comes from one of three fixed lengths, from compare register A, or from a separate period register. In the normal kind the ceiling is always 0xFFFF.

Each compare channel has a buffer register that software writes and an active register that the comparator uses. In the two PWM kinds, the buffer moves into the active register at one defined point in the count, so a duty cycle or period change never produces a glitch. In the other kinds a write takes effect at once. When register A sets the ceiling in a PWM kind, channel A gives up PWM and toggles instead. An overflow event and the two match events set sticky flags. Software clears a flag by writing 1 to it, and the interrupt line is high while any flag is set and enabled by its mask bit.

Software uses a plain single-cycle register port. A write lands on the clock edge where `wr_en` is high. Reads are combinational from `raddr`, so the port has no back-pressure and no handshake.

Top module: `tmr_core`

## Requirements
- R1: After reset the counter, the control register, the flags, the mask and both waveform outputs are 0, and `irq` is low.
- R2: The counter changes only on a clock edge where `tick` is high and control bit 0 (run) is 1, or when software writes the counter. Register addresses are: 0 control, 1 counter, 2 compare A, 3 compare B, 4 period, 5 flags, 6 mask. A write to the counter loads it directly.
- R3: With kind = 0 (control bits 2:1), the counter counts up and wraps from 0xFFFF to 0. The tick taken at 0xFFFF sets the overflow flag (flag bit 0).
- R4: With kind = 1 (clear at ceiling), the tick taken while the count equals the ceiling returns the counter to 0. The ceiling source is set by control bits 4:3: 0 fixed, 1 compare A, 2 period register. In kinds 0 and 1, a match toggles that channel's waveform output.
- R5: When the fixed source is selected, control bits 6:5 choose the ceiling: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF.
- R6: With kind = 2 (single-slope PWM), the tick at the ceiling wraps the counter to 0, sets the overflow flag and sets the waveform output to 1. A match clears the waveform output to 0.
- R7: With kind = 3 (dual-slope PWM), the counter rises to the ceiling and then falls to 0. A match while rising clears the output, and a match while falling sets it. The overflow flag is set by the tick that turns the counter around at 0.
- R8: In kinds 2 and 3, a compare write goes only to the buffer, and reads return the buffer. The active value is loaded from the buffer on the tick at the ceiling (kind 2) or on the tick at 0 (kind 3). In kinds 0 and 1, writes act immediately.
- R9: A tick taken while the count equals a channel's active compare value sets that channel's flag: A is flag bit 1 and B is flag bit 2.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. `irq` is the OR of the flag bits ANDed with the mask bits at the same positions.
- R11: When compare A is the ceiling source in kind 2 or 3, waveform A toggles on each A match instead of producing PWM, and the ceiling value is itself double-buffered as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Qualified count enable from the timer clock source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Write address |
| wdata | input | 16 | Write data |
| raddr | input | 3 | Read address |
| rdata | output | 16 | Read data (combinational) |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check on every cycle the local rules that hold in any state. The counter holds when it is not enabled, it wraps to 0 after the ceiling in kinds 1 and 2, and it turns around at the ceiling in kind 3. An active compare register never moves in a PWM kind except at its load point. A match always leaves its flag set, and the single-slope output is always high after the ceiling. Only the bench scenarios can show the full waveforms over many ticks. These include the toggle sequence, the clear and set pattern of the dual-slope mode, which of the three fixed ceilings applies, and whether a buffered write takes effect at the ceiling rather than at once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    K_NORM  = 2'd0,
    K_CTC   = 2'd1,
    K_FAST  = 2'd2,
    K_PHASE = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    S_FIX  = 2'd0,
    S_CMPA = 2'd1,
    S_PER  = 2'd2,
    S_RSV  = 2'd3
  } src_t;

  typedef struct packed {
    logic [1:0] fixw;
    src_t       src;
    kind_t      kind;
    logic       run;
  } ctrl_t;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_CNT  = 3'd1;
  localparam logic [AW-1:0] A_CMPA = 3'd2;
  localparam logic [AW-1:0] A_CMPB = 3'd3;
  localparam logic [AW-1:0] A_PER  = 3'd4;
  localparam logic [AW-1:0] A_FLG  = 3'd5;
  localparam logic [AW-1:0] A_MSK  = 3'd6;

  localparam int NFLAG = 3;
  localparam int F_OVF = 0;
endpackage

// File: rtl/tmr_ceiling.sv
module tmr_ceiling
  import tmr_pkg::*;
#(
  parameter int W = 16,
  parameter int FIX0_BITS = 8,
  parameter int FIX1_BITS = 9,
  parameter int FIX2_BITS = 10
) (
  input  ctrl_t        ctrl,
  input  logic [W-1:0] act_a,
  input  logic [W-1:0] per,
  output logic [W-1:0] top
);
  localparam logic [W-1:0] FIX0 = (W'(1) << FIX0_BITS) - W'(1);
  localparam logic [W-1:0] FIX1 = (W'(1) << FIX1_BITS) - W'(1);
  localparam logic [W-1:0] FIX2 = (W'(1) << FIX2_BITS) - W'(1);

  logic [W-1:0] fixv;

  always_comb begin
    unique case (ctrl.fixw)
      2'd0:    fixv = FIX0;
      2'd1:    fixv = FIX1;
      default: fixv = FIX2;
    endcase
  end

  always_comb begin
    if (ctrl.kind == K_NORM) begin
      top = '1;
    end else begin
      unique case (ctrl.src)
        S_CMPA:  top = act_a;
        S_PER:   top = per;
        default: top = fixv;
      endcase
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  kind_t        kind,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         dir_up,
  output logic         at_top,
  output logic         ovf_ev
);
  localparam logic [W-1:0] MAXV = '1;

  assign at_top = (cnt == top);

  always_comb begin
    unique case (kind)
      K_NORM, K_CTC: ovf_ev = en && (cnt == MAXV);
      K_FAST:        ovf_ev = en && at_top;
      default:       ovf_ev = en && !dir_up && (cnt == '0);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else begin
      if (kind != K_PHASE) dir_up <= 1'b1;
      if (ld) begin
        cnt <= ld_val;
      end else if (en) begin
        unique case (kind)
          K_NORM: cnt <= cnt + W'(1);
          K_CTC, K_FAST: cnt <= at_top ? '0 : cnt + W'(1);
          default: begin
            if (dir_up) begin
              if (cnt >= top) begin
                dir_up <= 1'b0;
                cnt    <= (cnt == '0) ? '0 : cnt - W'(1);
              end else begin
                cnt <= cnt + W'(1);
              end
            end else begin
              if (cnt == '0) begin
                dir_up <= 1'b1;
                cnt    <= (top == '0) ? '0 : W'(1);
              end else begin
                cnt <= cnt - W'(1);
              end
            end
          end
        endcase
      end
    end
  end

  // R2: no enable and no load keeps the count
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> $stable(cnt));

  // R4 / R6: single-slope kinds wrap to zero after the ceiling
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && (kind == K_CTC || kind == K_FAST) && cnt == top) |=> (cnt == '0));

  // R7: dual-slope turns around at a nonzero ceiling
  a_r7_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && kind == K_PHASE && dir_up && cnt == top && top != '0) |=> !dir_up);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         en,
  input  kind_t        kind,
  input  logic [W-1:0] cnt,
  input  logic         dir_up,
  input  logic         at_top,
  input  logic         as_top,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q,
  output logic         match_ev,
  output logic         wave
);
  logic pwm;
  logic load;

  assign pwm      = (kind == K_FAST) || (kind == K_PHASE);
  assign load     = en && ((kind == K_FAST) ? at_top : (cnt == '0));
  assign match_ev = en && (cnt == act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (we) buf_q <= wdata;
      if (!pwm)      act_q <= we ? wdata : buf_q;
      else if (load) act_q <= buf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave <= 1'b0;
    end else if (en) begin
      if (!pwm || as_top) begin
        if (match_ev) wave <= !wave;
      end else if (kind == K_FAST) begin
        if (at_top)        wave <= 1'b1;
        else if (match_ev) wave <= 1'b0;
      end else begin
        if (match_ev) wave <= !dir_up;
      end
    end
  end

  // R8: in PWM kinds the active value moves only at its load point
  a_r8_act_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !load) |=> $stable(act_q));

  // R6: single-slope output is high after the ceiling
  a_r6_set_top: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == K_FAST && at_top && !as_top) |=> wave);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [W-1:0]  wdata,
  input  logic [2:0]    raddr,
  output logic [W-1:0]  rdata,
  output logic          wave_a,
  output logic          wave_b,
  output logic          irq
);
  localparam int NCH = 2;
  localparam int CW  = $bits(ctrl_t);

  ctrl_t            ctrl;
  logic [W-1:0]     per;
  logic [NFLAG-1:0] flags, mask, set_ev, clr;
  logic             en, pwm;
  logic [W-1:0]     top, cnt;
  logic             dir_up, at_top, ovf_ev;
  logic [W-1:0]     buf_q [NCH];
  logic [W-1:0]     act_q [NCH];
  logic [NCH-1:0]   match_ev, wave;

  assign en  = ctrl.run && tick;
  assign pwm = (ctrl.kind == K_FAST) || (ctrl.kind == K_PHASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      per  <= '0;
      mask <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl <= ctrl_t'(wdata[CW-1:0]);
      if (addr == A_PER)  per  <= wdata;
      if (addr == A_MSK)  mask <= wdata[NFLAG-1:0];
    end
  end

  tmr_ceiling #(.W(W)) u_ceil (
    .ctrl (ctrl),
    .act_a(act_q[0]),
    .per  (per),
    .top  (top)
  );

  tmr_count #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .ld    (wr_en && addr == A_CNT),
    .ld_val(wdata),
    .kind  (ctrl.kind),
    .top   (top),
    .cnt   (cnt),
    .dir_up(dir_up),
    .at_top(at_top),
    .ovf_ev(ovf_ev)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [2:0] MYADDR = (i == 0) ? A_CMPA : A_CMPB;
    tmr_chan #(.W(W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en && addr == MYADDR),
      .wdata   (wdata),
      .en      (en),
      .kind    (ctrl.kind),
      .cnt     (cnt),
      .dir_up  (dir_up),
      .at_top  (at_top),
      .as_top  ((i == 0) && pwm && (ctrl.src == S_CMPA)),
      .buf_q   (buf_q[i]),
      .act_q   (act_q[i]),
      .match_ev(match_ev[i]),
      .wave    (wave[i])
    );
  end

  assign set_ev = {match_ev, ovf_ev};
  assign clr    = (wr_en && addr == A_FLG) ? wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set_ev;
  end

  assign irq    = |(flags & mask);
  assign wave_a = wave[0];
  assign wave_b = wave[1];

  always_comb begin
    unique case (raddr)
      A_CTRL:  rdata = W'(ctrl);
      A_CNT:   rdata = cnt;
      A_CMPA:  rdata = buf_q[0];
      A_CMPB:  rdata = buf_q[1];
      A_PER:   rdata = per;
      A_FLG:   rdata = W'(flags);
      A_MSK:   rdata = W'(mask);
      default: rdata = '0;
    endcase
  end

  // R9: a match event always leaves its flag set
  a_r9_flag_a: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev[0] |=> flags[1]);
  a_r9_flag_b: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev[1] |=> flags[2]);

  // R10: writing all ones with no new event empties the flags
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FLG && wdata[NFLAG-1:0] == '1 && set_ev == '0) |=> (flags == '0));
endmodule

// File: tb/tb_tmr_core.sv
module tb_tmr_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [2:0]  raddr = '0;
  logic [15:0] rdata;
  logic        wave_a, wave_b, irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit probe = 0;

  int    q_kind[$];
  int    q_exp[$];
  string q_tag[$];

  always #2 clk = ~clk;

  tmr_core dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .raddr(raddr), .rdata(rdata), .wave_a(wave_a),
    .wave_b(wave_b), .irq(irq)
  );

  // monitor: pops expected items and compares with the outputs
  always @(negedge clk) begin
    if (probe) begin
      int k, e, g;
      string t;
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      case (k)
        0: g = int'(rdata);
        1: g = int'(wave_a);
        2: g = int'(wave_b);
        default: g = int'(irq);
      endcase
      total++;
      if (g != e) begin
        bad++;
        $display("FAIL %s got=%h exp=%h", t, g, e);
      end
      probe = 0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: push expectation, let the monitor sample
  task automatic chk(input int k, input int a, input int e, input string t);
    raddr = a[2:0];
    q_kind.push_back(k);
    q_exp.push_back(e);
    q_tag.push_back(t);
    probe = 1;
    @(negedge clk); #1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog got=hang exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(0, 1, 0, "R1 cnt");
    chk(0, 0, 0, "R1 ctrl");
    chk(0, 5, 0, "R1 flags");
    chk(1, 0, 0, "R1 wave_a");
    chk(2, 0, 0, "R1 wave_b");
    chk(3, 0, 0, "R1 irq");

    // R2 run gating
    wr(0, 16'h0000);
    ticks(5);
    chk(0, 1, 0, "R2 stopped");
    wr(0, 16'h0001);
    idle(3);
    chk(0, 1, 0, "R2 no tick");
    ticks(5);
    chk(0, 1, 5, "R2 count");
    chk(0, 5, 6, "R9 zero match both");
    chk(1, 0, 1, "R4 toggle normal a");
    wr(5, 16'h0007);

    // R3 wrap + R12-style load (R2)
    wr(1, 16'hFFFE);
    ticks(1);
    chk(0, 1, 16'hFFFF, "R2 load");
    chk(0, 5, 0, "R3 no ovf yet");
    ticks(1);
    chk(0, 1, 0, "R3 wrap");
    chk(0, 5, 1, "R3 ovf flag");
    chk(3, 0, 0, "R10 masked");
    wr(6, 16'h0001);
    chk(3, 0, 1, "R10 irq");
    wr(5, 16'h0001);
    chk(0, 5, 0, "R10 w1c");
    chk(3, 0, 0, "R10 irq low");

    // R4 clear at period register
    wr(4, 16'd9);
    wr(3, 16'd4);
    wr(0, 16'h0013);
    wr(1, 16'h0000);
    ticks(10);
    chk(0, 1, 0, "R4 period wrap");
    chk(0, 5, 6, "R9 ctc flags");
    chk(1, 0, 0, "R4 toggle a");
    chk(2, 0, 0, "R4 toggle b");
    ticks(10);
    chk(1, 0, 1, "R4 toggle a again");
    chk(2, 0, 1, "R4 toggle b again");
    wr(5, 16'h0007);
    // R4 clear at compare A
    wr(2, 16'd5);
    wr(0, 16'h000B);
    wr(1, 16'h0000);
    ticks(6);
    chk(0, 1, 0, "R4 cmpa wrap");
    chk(1, 0, 0, "R4 cmpa toggle");
    ticks(3);
    chk(0, 1, 3, "R4 after wrap");

    // R5 fixed ceilings
    for (int w = 0; w < 3; w++) begin
      wr(0, 16'(16'h0003 | (w << 5)));
      wr(1, 16'((1 << (8 + w)) - 2));
      ticks(2);
      chk(0, 1, 0, "R5 fixed wrap");
    end
    wr(0, 16'h0023);
    wr(1, 16'h00FE);
    ticks(2);
    chk(0, 1, 16'h0100, "R5 width1 passes 0xFF");

    // R6 / R8 single-slope PWM
    wr(0, 16'h0004);
    wr(1, 16'h0000);
    wr(3, 16'h0010);
    chk(0, 3, 16'h0010, "R8 read buffer");
    wr(5, 16'h0007);
    wr(0, 16'h0005);
    ticks(5);
    chk(0, 5, 4, "R8 old active matched");
    wr(1, 16'h00FE);
    ticks(2);
    chk(0, 1, 0, "R6 wrap");
    chk(1, 0, 1, "R6 set a");
    chk(2, 0, 1, "R6 set b");
    chk(0, 5, 5, "R6 ovf flag");
    ticks(16);
    chk(1, 0, 0, "R6 clear a");
    chk(2, 0, 1, "R8 new active b");
    ticks(1);
    chk(2, 0, 0, "R6 clear b");

    // R11 compare A as ceiling in PWM
    wr(0, 16'h000C);
    wr(1, 16'h0000);
    wr(5, 16'h0007);
    wr(0, 16'h000D);
    ticks(6);
    chk(0, 1, 0, "R11 wrap at A");
    chk(1, 0, 1, "R11 toggle");
    chk(0, 5, 3, "R11 flags");
    wr(2, 16'd3);
    ticks(4);
    chk(0, 1, 4, "R11 top buffered");
    ticks(2);
    chk(0, 1, 0, "R11 old top");
    chk(1, 0, 0, "R11 toggle back");
    ticks(4);
    chk(0, 1, 0, "R11 new top");
    chk(1, 0, 1, "R11 toggle new");

    // R7 dual-slope
    wr(0, 16'h0002);
    wr(3, 16'h00FE);
    wr(0, 16'h0006);
    wr(1, 16'h00FD);
    wr(5, 16'h0007);
    wr(0, 16'h0007);
    ticks(2);
    chk(0, 1, 16'h00FF, "R7 rise");
    chk(2, 0, 0, "R7 clear rising");
    ticks(1);
    chk(0, 1, 16'h00FE, "R7 fall");
    ticks(1);
    chk(0, 1, 16'h00FD, "R7 fall 2");
    chk(2, 0, 1, "R7 set falling");
    wr(1, 16'h0001);
    ticks(1);
    chk(0, 1, 0, "R7 bottom");
    chk(0, 5, 4, "R7 no ovf yet");
    ticks(1);
    chk(0, 1, 1, "R7 turn up");
    chk(0, 5, 5, "R7 ovf at bottom");
    wr(6, 16'h0004);
    chk(3, 0, 1, "R10 mask b");
    wr(6, 16'h0002);
    chk(3, 0, 0, "R10 mask a");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule